// File: doc/BRIEF.md
# DDR Command Decoder and Bank Tracker

This block watches the command and address pins of a double-data-rate SDRAM and samples them on every rising clock edge. It turns the chip-select, RAS, CAS and WE lines into one typed command. It reports that command one cycle later together with the bank, the row or column address, the auto-precharge request and whether a mode-register write targets the extended register.

Alongside the decoder it keeps the state of each bank: whether the bank is idle or has a row open, and which row that is. It closes banks on precharge, on precharge-all and at the end of a burst that asked for auto-precharge. Commands that do not fit the current bank state are flagged with an error code. A controller can use it as a protocol monitor, or it can serve as the front end of a memory model. Timing-parameter checking, the data path, the strobes and the DLL are not part of it.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When cke is high and csN is low, the pattern {rasN,casN,weN} is decoded and shown on cmdCode after the next rising edge. 011 gives ACT=1, 101 gives RD=2, 100 gives WR=3, 010 gives PRE=4, 001 gives REF=5 and 000 gives MRS=6. Every other pattern, including 111 and 110, gives NOP=0. cmdBank shows ba for a decoded non-NOP command and 0 otherwise.
- R2: While csN is high the command is reported as NOP with errKind 0 and no bank is opened or closed by it. A pending auto-precharge countdown still runs to completion.
- R3: cmdAddr carries addr[11:0] for ACT, the column addr[7:0] zero-extended for RD and WR, and the whole of addr for MRS. It is 0 for all other commands. cmdAutoPre equals addr[10] on RD and WR and is 0 otherwise.
- R4: A legal ACT sets bankOpen[bank] and stores the row in openRows[bank*12 +: 12].
- R5: PRE with addr[10] low closes only the bank selected by ba. PRE with addr[10] high closes all four banks, whatever ba holds, and raises cmdAllBanks.
- R6: errKind is 1 for RD or WR to an idle bank, 2 for ACT to an open bank, 3 for REF or MRS while any bank is open, and 0 otherwise. A command flagged with an error changes no bank state and no stored row.
- R7: A legal RD or WR with addr[10] high closes its bank at the rising edge BL/2+1 edges after the command edge. The burst length BL comes from blSel: 01 gives 2, 10 gives 4, 11 gives 8, and 00 is treated as 2.
- R8: On MRS, cmdExtMode equals ba[0] (1 selects the extended mode register). It is 0 for every other command.
- R9: While cke is sampled low, commands are reported as NOP. lowPower is 1 after an edge where cke was low and all banks were idle, and 0 otherwise.
- R10: While rstN is low, every output is 0 and all banks are idle.

Assertions are labelled with the same R numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, active high |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus |
| blSel | input | 2 | Configured burst length code |
| cmdCode | output | 3 | Decoded command |
| cmdBank | output | 2 | Bank of the decoded command |
| cmdAddr | output | 12 | Row, column or mode payload |
| cmdAutoPre | output | 1 | Auto-precharge requested |
| cmdAllBanks | output | 1 | Precharge applied to all banks |
| cmdExtMode | output | 1 | MRS targets the extended register |
| errKind | output | 2 | Protocol violation code |
| bankOpen | output | 4 | Open flag per bank |
| openRows | output | 48 | Open row per bank, 12 bits each |
| lowPower | output | 1 | Clock disabled with all banks idle |

## Verification
The following properties are checked on every cycle:
- A deselected cycle never yields a command or an error.
- An idle-bank error only accompanies reads or writes.
- A precharge-all leaves every bank closed.
- A legal activate leaves its bank open.
- The low-power flag never coexists with an open bank.

Some behaviour can only be shown by the bench's sequences:
- The exact edge at which an auto-precharge closes its bank, for each burst length.
- That the countdown survives deselected cycles.
- That a rejected activate keeps the old row.
- The address and field routing for each command.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_IDLE = 2'd1,
    ERR_REOPEN = 2'd2,
    ERR_BUSY = 2'd3
  } err_e;

  localparam int AP_LEN_W = 4;

  // strobes from the control to the bank datapath
  typedef struct packed {
    logic                actEn;
    logic                preSel;
    logic                preAll;
    logic                apLoad;
    logic [AP_LEN_W-1:0] apLen;
  } strobe_t;

endpackage

// File: rtl/ddr_trk_ctrl.sv
module ddr_trk_ctrl
  import ddr_trk_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  input  logic [1:0]       blSel,
  input  logic [BANKS-1:0] bankOpen,
  output strobe_t          stb,
  output logic [2:0]       cmdCode,
  output logic [BA_W-1:0]  cmdBank,
  output logic [ROW_W-1:0] cmdAddr,
  output logic             cmdAutoPre,
  output logic             cmdAllBanks,
  output logic             cmdExtMode,
  output logic [1:0]       errKind,
  output logic             lowPower
);

  cmd_e             cmd;
  err_e             err;
  logic [ROW_W-1:0] repAddr;
  logic             anyOpen;
  logic             selOpen;
  logic             apReq;

  assign anyOpen = |bankOpen;
  assign selOpen = bankOpen[ba];
  assign apReq   = addr[AP_BIT];

  always_comb begin
    cmd = CMD_NOP;
    if (cke && !csN) begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    err = ERR_NONE;
    case (cmd)
      CMD_RD, CMD_WR:   if (!selOpen) err = ERR_IDLE;
      CMD_ACT:          if (selOpen)  err = ERR_REOPEN;
      CMD_REF, CMD_MRS: if (anyOpen)  err = ERR_BUSY;
      default:          err = ERR_NONE;
    endcase
  end

  always_comb begin
    repAddr = '0;
    case (cmd)
      CMD_ACT, CMD_MRS: repAddr = addr;
      CMD_RD, CMD_WR:   repAddr = {{(ROW_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      default:          repAddr = '0;
    endcase
  end

  always_comb begin
    stb.actEn  = (cmd == CMD_ACT) && (err == ERR_NONE);
    stb.preSel = (cmd == CMD_PRE) && !apReq;
    stb.preAll = (cmd == CMD_PRE) && apReq;
    stb.apLoad = ((cmd == CMD_RD) || (cmd == CMD_WR)) && (err == ERR_NONE) && apReq;
    case (blSel)
      2'd2:    stb.apLen = AP_LEN_W'(3);
      2'd3:    stb.apLen = AP_LEN_W'(5);
      default: stb.apLen = AP_LEN_W'(2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode     <= CMD_NOP;
      cmdBank     <= '0;
      cmdAddr     <= '0;
      cmdAutoPre  <= 1'b0;
      cmdAllBanks <= 1'b0;
      cmdExtMode  <= 1'b0;
      errKind     <= ERR_NONE;
      lowPower    <= 1'b0;
    end else begin
      cmdCode     <= cmd;
      cmdBank     <= (cmd == CMD_NOP) ? '0 : ba;
      cmdAddr     <= repAddr;
      cmdAutoPre  <= ((cmd == CMD_RD) || (cmd == CMD_WR)) && apReq;
      cmdAllBanks <= stb.preAll;
      cmdExtMode  <= (cmd == CMD_MRS) && ba[0];
      errKind     <= err;
      lowPower    <= !cke && !anyOpen;
    end
  end

endmodule

// File: rtl/ddr_trk_banks.sv
module ddr_trk_banks
  import ddr_trk_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [BANKS-1:0]       bankOpen,
  output logic [BANKS*ROW_W-1:0] openRows
);

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    logic [AP_LEN_W-1:0] apCnt;
    logic                hit;

    assign hit = (ba == BA_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[gi]                  <= 1'b0;
        openRows[gi*ROW_W +: ROW_W]   <= '0;
        apCnt                         <= '0;
      end else if (stb.preAll || (stb.preSel && hit)) begin
        bankOpen[gi] <= 1'b0;
        apCnt        <= '0;
      end else if (apCnt == AP_LEN_W'(1)) begin
        bankOpen[gi] <= 1'b0;
        apCnt        <= '0;
      end else begin
        if (stb.actEn && hit) begin
          bankOpen[gi]                <= 1'b1;
          openRows[gi*ROW_W +: ROW_W] <= addr;
        end
        if (stb.apLoad && hit)
          apCnt <= stb.apLen;
        else if (apCnt != '0)
          apCnt <= apCnt - AP_LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  input  logic [1:0]             blSel,
  output logic [2:0]             cmdCode,
  output logic [BA_W-1:0]        cmdBank,
  output logic [ROW_W-1:0]       cmdAddr,
  output logic                   cmdAutoPre,
  output logic                   cmdAllBanks,
  output logic                   cmdExtMode,
  output logic [1:0]             errKind,
  output logic [BANKS-1:0]       bankOpen,
  output logic [BANKS*ROW_W-1:0] openRows,
  output logic                   lowPower
);

  strobe_t stb;

  ddr_trk_ctrl #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .blSel(blSel),
    .bankOpen(bankOpen), .stb(stb), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdAutoPre(cmdAutoPre), .cmdAllBanks(cmdAllBanks),
    .cmdExtMode(cmdExtMode), .errKind(errKind), .lowPower(lowPower)
  );

  ddr_trk_banks #(
    .BANKS(BANKS), .ROW_W(ROW_W)
  ) banks_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ba(ba), .addr(addr),
    .bankOpen(bankOpen), .openRows(openRows)
  );

endmodule

// File: rtl/ddr_trk_checker.sv
module ddr_trk_checker
  import ddr_trk_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cke,
  input logic             csN,
  input logic [2:0]       cmdCode,
  input logic [BA_W-1:0]  cmdBank,
  input logic             cmdAllBanks,
  input logic [1:0]       errKind,
  input logic [BANKS-1:0] bankOpen,
  input logic             lowPower
);

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (cmdCode == CMD_NOP) && (errKind == ERR_NONE)); // R2

  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cke) |-> (cmdCode == CMD_NOP)); // R9

  AST_IDLE_ERR_RDWR: assert property (@(posedge clk) disable iff (!rstN)
    (errKind == ERR_IDLE) |-> ((cmdCode == CMD_RD) || (cmdCode == CMD_WR))); // R6

  AST_PRE_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == CMD_PRE) && cmdAllBanks) |-> (bankOpen == '0)); // R5

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == CMD_ACT) && (errKind == ERR_NONE)) |-> bankOpen[cmdBank]); // R4

  AST_LOWPWR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> (bankOpen == '0)); // R9

endmodule

bind ddr_cmd_tracker ddr_trk_checker #(.BANKS(BANKS), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .cmdCode(cmdCode),
  .cmdBank(cmdBank), .cmdAllBanks(cmdAllBanks), .errKind(errKind),
  .bankOpen(bankOpen), .lowPower(lowPower)
);

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1;
  logic        csN = 1'b1;
  logic        rasN = 1'b1;
  logic        casN = 1'b1;
  logic        weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  blSel = 2'd2;
  logic [2:0]  cmdCode;
  logic [1:0]  cmdBank;
  logic [11:0] cmdAddr;
  logic        cmdAutoPre;
  logic        cmdAllBanks;
  logic        cmdExtMode;
  logic [1:0]  errKind;
  logic [3:0]  bankOpen;
  logic [47:0] openRows;
  logic        lowPower;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_tracker dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .blSel(blSel), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .cmdAutoPre(cmdAutoPre),
    .cmdAllBanks(cmdAllBanks), .cmdExtMode(cmdExtMode), .errKind(errKind),
    .bankOpen(bankOpen), .openRows(openRows), .lowPower(lowPower)
  );

  typedef struct packed {
    logic        cs;
    logic        ras;
    logic        cas;
    logic        we;
    logic [1:0]  vBa;
    logic [11:0] vAddr;
    logic [2:0]  eCode;
    logic [1:0]  eBank;
    logic [11:0] eAddr;
    logic        eAp;
    logic        eAll;
    logic        eExt;
    logic [1:0]  eErr;
    logic [3:0]  eOpen;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,1'b1,1'b1, 2'd0, 12'h000, 3'd0, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd0, 4'b0000}, // NOP
    '{1'b0,1'b0,1'b1,1'b1, 2'd0, 12'h123, 3'd1, 2'd0, 12'h123, 1'b0,1'b0,1'b0, 2'd0, 4'b0001}, // ACT b0
    '{1'b0,1'b0,1'b1,1'b1, 2'd0, 12'h055, 3'd1, 2'd0, 12'h055, 1'b0,1'b0,1'b0, 2'd2, 4'b0001}, // ACT open
    '{1'b0,1'b1,1'b0,1'b1, 2'd1, 12'h0FF, 3'd2, 2'd1, 12'h0FF, 1'b0,1'b0,1'b0, 2'd1, 4'b0001}, // RD idle
    '{1'b0,1'b0,1'b1,1'b1, 2'd2, 12'hABC, 3'd1, 2'd2, 12'hABC, 1'b0,1'b0,1'b0, 2'd0, 4'b0101}, // ACT b2
    '{1'b0,1'b1,1'b0,1'b0, 2'd2, 12'hB45, 3'd3, 2'd2, 12'h045, 1'b0,1'b0,1'b0, 2'd0, 4'b0101}, // WR b2
    '{1'b0,1'b0,1'b0,1'b1, 2'd0, 12'h000, 3'd5, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd3, 4'b0101}, // REF busy
    '{1'b0,1'b0,1'b0,1'b0, 2'd1, 12'h021, 3'd6, 2'd1, 12'h021, 1'b0,1'b0,1'b1, 2'd3, 4'b0101}, // MRS busy ext
    '{1'b1,1'b0,1'b1,1'b1, 2'd1, 12'h777, 3'd0, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd0, 4'b0101}, // deselect
    '{1'b0,1'b0,1'b1,1'b0, 2'd0, 12'h000, 3'd4, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd0, 4'b0100}, // PRE b0
    '{1'b0,1'b1,1'b0,1'b1, 2'd2, 12'h07F, 3'd2, 2'd2, 12'h07F, 1'b0,1'b0,1'b0, 2'd0, 4'b0100}, // RD b2
    '{1'b0,1'b0,1'b1,1'b0, 2'd3, 12'h400, 3'd4, 2'd3, 12'h000, 1'b0,1'b1,1'b0, 2'd0, 4'b0000}, // PRE all
    '{1'b0,1'b0,1'b0,1'b1, 2'd0, 12'h000, 3'd5, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd0, 4'b0000}, // REF ok
    '{1'b0,1'b0,1'b0,1'b0, 2'd0, 12'h062, 3'd6, 2'd0, 12'h062, 1'b0,1'b0,1'b0, 2'd0, 4'b0000}, // MRS main
    '{1'b0,1'b1,1'b1,1'b0, 2'd0, 12'h000, 3'd0, 2'd0, 12'h000, 1'b0,1'b0,1'b0, 2'd0, 4'b0000}  // 110 -> NOP
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive a command, let one rising edge pass, return at the falling edge
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [11:0] a);
    csN = c; rasN = r; casN = ca; weN = w; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    issue(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 12'h000);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "cmdCode", 64'(cmdCode), 64'd0);
    check("R10", "bankOpen", 64'(bankOpen), 64'd0);
    check("R10", "openRows", 64'(openRows), 64'd0);
    check("R10", "errKind/lowPower", 64'({errKind, lowPower}), 64'd0);
    rstN = 1'b1;

    // table walk: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].cs, VECS[i].ras, VECS[i].cas, VECS[i].we, VECS[i].vBa, VECS[i].vAddr);
      check("R1", "cmdCode", 64'(cmdCode), 64'(VECS[i].eCode));
      check("R1", "cmdBank", 64'(cmdBank), 64'(VECS[i].eBank));
      check("R3", "cmdAddr", 64'(cmdAddr), 64'(VECS[i].eAddr));
      check("R3", "cmdAutoPre", 64'(cmdAutoPre), 64'(VECS[i].eAp));
      check("R5", "cmdAllBanks", 64'(cmdAllBanks), 64'(VECS[i].eAll));
      check("R8", "cmdExtMode", 64'(cmdExtMode), 64'(VECS[i].eExt));
      check("R6", "errKind", 64'(errKind), 64'(VECS[i].eErr));
      check("R2", "bankOpen", 64'(bankOpen), 64'(VECS[i].eOpen));
    end

    // R4 and R6: stored row survives a rejected activate
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 12'h111);
    check("R4", "row b0", 64'(openRows[11:0]), 64'h111);
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 12'h222);
    check("R6", "row kept", 64'(openRows[11:0]), 64'h111);
    issue(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h400);

    // R7: BL4 auto-precharge closes bank 1 three edges after the read
    blSel = 2'd2;
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 12'h3C3);
    check("R4", "row b1", 64'(openRows[23:12]), 64'h3C3);
    issue(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 12'h410);
    check("R3", "ap col", 64'({cmdAutoPre, cmdAddr}), 64'({1'b1, 12'h010}));
    nop();
    nop();
    check("R7", "BL4 still open", 64'(bankOpen[1]), 64'd1);
    nop();
    check("R7", "BL4 closed", 64'(bankOpen[1]), 64'd0);

    // R7 and R2: BL8 write with AP continues through deselected cycles
    blSel = 2'd3;
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 12'h0A5);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 12'h401);
    for (int k = 0; k < 4; k++) issue(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 12'h000);
    check("R7", "BL8 still open", 64'(bankOpen[3]), 64'd1);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 12'h000);
    check("R2", "BL8 closed while deselected", 64'(bankOpen[3]), 64'd0);

    // R7: code 00 behaves as BL2
    blSel = 2'd0;
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 12'h001);
    issue(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 12'h400);
    nop();
    check("R7", "BL2 still open", 64'(bankOpen[2]), 64'd1);
    nop();
    check("R7", "BL2 closed", 64'(bankOpen[2]), 64'd0);

    // R9: clock enable low ignores an activate and flags low power
    cke = 1'b0;
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 12'h100);
    check("R9", "cke low cmd", 64'(cmdCode), 64'd0);
    check("R9", "cke low banks", 64'(bankOpen), 64'd0);
    check("R9", "lowPower set", 64'(lowPower), 64'd1);
    cke = 1'b1;
    nop();
    check("R9", "lowPower clear", 64'(lowPower), 64'd0);

    // R9: clock enable low with a bank open does not flag low power
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 12'h100);
    cke = 1'b0;
    nop();
    check("R9", "lowPower with open bank", 64'(lowPower), 64'd0);
    cke = 1'b1;

    finish_run();
  end

endmodule